// File: doc/BRIEF.md
# Serial PCM Receive Port

This block takes one 8-bit companded voice sample per frame off a serial PCM line and hands it to the rest of the chip as a parallel byte. It runs entirely on the system clock. The line clocks, frame sync and data are asynchronous inputs. Each one passes through a synchronizer, and the block finds their edges from the synchronized samples. For this to work, the system clock must run at least four times faster than the fastest bit clock.

A static strap picks one of two framing schemes:

- **Fixed-rate mode.** The bit clock is the master clock. A rising frame-sync pulse starts a word.
- **Variable-rate mode.** A separate receive data clock carries the bits. The frame-sync pin acts as a time-slot enable level that must stay high for the whole word.

The block also watches for frame sync staying low too long, and raises a standby flag when it does. A single rising frame-sync edge clears the flag again.

Top module: `pcm_rx_port`

## Requirements
- R1: While reset is held and right after it, `word_o` is 0, `word_valid_o` is 0 and `standby_o` is 0.
- R2: In fixed-rate mode (`var_mode_i`=0), the word is built from the first eight falling edges of `mclk_i` after a rising edge of `fsync_i`. The first bit taken is bit 7 (MSB) and the eighth is bit 0 (LSB).
- R3: Each completed word raises `word_valid_o` for exactly one system clock cycle. Falling bit-clock edges after the eighth produce no further word until the next rising frame-sync edge.
- R4: In variable-rate mode (`var_mode_i`=1), bits are taken only on falling edges of `dclk_i` while `fsync_i` is high. Falling edges of `mclk_i` have no effect.
- R5: In variable-rate mode, if `fsync_i` goes low before the eighth bit, the partial word is dropped. No valid pulse appears and `word_o` keeps the previous word.
- R6: A new rising edge of `fsync_i` during a word restarts the bit count. The word then delivered holds only the eight bits that follow the new edge.
- R7: `standby_o` goes high once `fsync_i` has stayed low for more than `STANDBY_CYCLES` system clock cycles. It stays low while the low time is well below that.
- R8: `standby_o` clears on the next rising edge of `fsync_i`, and a word framed by that edge is received normally.
- R9: In fixed-rate mode, falling edges of `dclk_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| var_mode_i | input | 1 | Static strap: 0 fixed-rate, 1 variable-rate |
| mclk_i | input | 1 | Master clock, the bit clock in fixed-rate mode |
| dclk_i | input | 1 | Receive data clock, the bit clock in variable-rate mode |
| fsync_i | input | 1 | Frame sync pulse (fixed) or time-slot enable level (variable) |
| sdata_i | input | 1 | Serial PCM data, MSB first |
| word_o | output | 8 | Last completed word |
| word_valid_o | output | 1 | One-cycle strobe when `word_o` is updated |
| standby_o | output | 1 | Receive standby flag after a frame-sync absence |

## Verification
The bench builds the port with `STANDBY_CYCLES` set to 300 instead of the 30 ms default. This brings both sides of the frame-sync absence timeout, and the exit from standby, within a few hundred cycles. Word width and synchronizer depth keep their defaults. The bit clocks run at one eighth of the system clock, so every edge-detection and data-alignment path is exercised at twice the minimum oversampling margin.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int unsigned IN_MCLK = 0;
  localparam int unsigned IN_DCLK = 1;
  localparam int unsigned IN_FS   = 2;
  localparam int unsigned IN_DAT  = 3;
  localparam int unsigned N_IN    = 4;

  typedef enum logic {
    MODE_FIXED = 1'b0,
    MODE_VAR   = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= stg[STAGES-1];
  end

  assign q_o    = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~last_q;
  assign fall_o = ~stg[STAGES-1] & last_q;
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
  import pcm_rx_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  rx_mode_e             mode_i,
  input  logic                 start_i,
  input  logic                 gate_i,
  input  logic                 bit_fall_i,
  input  logic                 bit_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o
);
  localparam int unsigned CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic                 armed_q;
  logic [CW-1:0]        cnt_q;
  logic [WORD_BITS-1:0] shreg_q;
  logic [WORD_BITS-1:0] next_shreg;

  assign next_shreg = {shreg_q[WORD_BITS-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q) begin
        // time-slot enable must cover the whole word in variable mode
        if (mode_i == MODE_VAR && !gate_i) begin
          armed_q <= 1'b0;
        end else if (bit_fall_i) begin
          shreg_q <= next_shreg;
          if (cnt_q == LAST) begin
            armed_q <= 1'b0;
            word_o  <= next_shreg;
            valid_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_standby.sv
module pcm_rx_standby #(
  parameter int unsigned TIMEOUT = 3_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_level_i,
  input  logic fs_rise_i,
  output logic standby_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT);

  logic [TW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      standby_o <= 1'b0;
    end else if (fs_rise_i) begin
      low_cnt_q <= '0;
      standby_o <= 1'b0;
    end else if (fs_level_i) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q != LIMIT) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end else begin
      standby_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
  import pcm_rx_pkg::*;
#(
  parameter int unsigned WORD_BITS      = 8,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned STANDBY_CYCLES = 3_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 var_mode_i,
  input  logic                 mclk_i,
  input  logic                 dclk_i,
  input  logic                 fsync_i,
  input  logic                 sdata_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_valid_o,
  output logic                 standby_o
);
  logic [N_IN-1:0] raw, syn, rise, fall;
  logic fs_sync, fs_rise, bit_fall;
  rx_mode_e mode;
  logic unused_edges;

  always_comb begin
    raw          = '0;
    raw[IN_MCLK] = mclk_i;
    raw[IN_DCLK] = dclk_i;
    raw[IN_FS]   = fsync_i;
    raw[IN_DAT]  = sdata_i;
  end

  pcm_rx_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign mode     = rx_mode_e'(var_mode_i);
  assign fs_sync  = syn[IN_FS];
  assign fs_rise  = rise[IN_FS];
  assign bit_fall = (mode == MODE_VAR) ? fall[IN_DCLK] : fall[IN_MCLK];
  assign unused_edges = ^{rise[IN_MCLK], rise[IN_DCLK], rise[IN_DAT],
                          fall[IN_FS], fall[IN_DAT], syn[IN_MCLK], syn[IN_DCLK]};

  pcm_rx_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .start_i   (fs_rise),
    .gate_i    (fs_sync),
    .bit_fall_i(bit_fall),
    .bit_i     (syn[IN_DAT]),
    .word_o    (word_o),
    .valid_o   (word_valid_o)
  );

  pcm_rx_standby #(.TIMEOUT(STANDBY_CYCLES)) u_stby (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fs_level_i(fs_sync),
    .fs_rise_i (fs_rise),
    .standby_o (standby_o)
  );
endmodule

// File: rtl/pcm_rx_port_chk.sv
module pcm_rx_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic var_mode_i,
  input logic word_valid_o,
  input logic standby_o,
  input logic fs_sync,
  input logic fs_rise,
  input logic bit_fall
);
  assert_valid_after_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(bit_fall));

  assert_valid_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  assert_discard_on_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && var_mode_i) |-> $past(fs_sync));

  assert_standby_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> $past(!fs_sync));

  assert_standby_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && fs_rise) |=> !standby_o);
endmodule

bind pcm_rx_port pcm_rx_port_chk u_chk (.*);

// File: tb/sim_pcm_rx_port.sv
module sim_pcm_rx_port;
  logic clk = 1'b0;
  logic rst_ni, var_mode, mclk, dclk, fs, dat;
  logic [7:0] word;
  logic word_valid, standby;
  int total = 0, bad = 0, vcnt = 0;
  logic [7:0] vword = '0;

  always #5 clk = ~clk;

  pcm_rx_port #(.STANDBY_CYCLES(300)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .var_mode_i(var_mode), .mclk_i(mclk),
    .dclk_i(dclk), .fsync_i(fs), .sdata_i(dat),
    .word_o(word), .word_valid_o(word_valid), .standby_o(standby)
  );

  always @(negedge clk) if (word_valid) begin vcnt++; vword = word; end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(bit use_d, bit b);
    dat = b;
    if (use_d) dclk = 1'b1; else mclk = 1'b1;
    tick(4);
    if (use_d) dclk = 1'b0; else mclk = 1'b0;
    tick(4);
  endtask

  task automatic send(bit use_d, logic [7:0] w, int first, int n);
    for (int i = first; i < first + n; i++) pulse(use_d, w[7-i]);
  endtask

  task automatic fixed_frame(logic [7:0] w);
    fs = 1'b1; tick(4);
    pulse(1'b0, w[7]);
    fs = 1'b0;
    send(1'b0, w, 1, 7);
    tick(4);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; var_mode = 1'b0; mclk = 0; dclk = 0; fs = 0; dat = 0;
    tick(3);
    check("R1 word", word, 0);
    check("R1 valid", word_valid, 0);
    check("R1 standby", standby, 0);
    rst_ni = 1'b1; tick(3);
    check("R1 valid after release", vcnt, 0);
  endtask

  task automatic t_fixed();
    var_mode = 1'b0;
    vcnt = 0; fixed_frame(8'hA5);
    check("R2 count", vcnt, 1); check("R2 word A5", vword, 8'hA5);
    vcnt = 0; fixed_frame(8'h3C);
    check("R2 count", vcnt, 1); check("R2 word 3C", vword, 8'h3C);
    vcnt = 0; send(1'b0, 8'hFF, 0, 8); tick(4);
    check("R3 no word without frame sync", vcnt, 0);
  endtask

  task automatic t_fixed_dclk_ignored();
    var_mode = 1'b0; vcnt = 0;
    fs = 1'b1; tick(4); fs = 1'b0;
    send(1'b1, 8'h00, 0, 8); tick(4);
    check("R9 dclk ignored", vcnt, 0);
    send(1'b0, 8'h69, 0, 8); tick(4);
    check("R9 mclk count", vcnt, 1); check("R9 word", vword, 8'h69);
  endtask

  task automatic t_restart();
    var_mode = 1'b0; vcnt = 0;
    fs = 1'b1; tick(4); pulse(1'b0, 1'b1); fs = 1'b0;
    send(1'b0, 8'hFF, 1, 2);
    fixed_frame(8'h5A);
    check("R6 count", vcnt, 1); check("R6 word", vword, 8'h5A);
  endtask

  task automatic t_var();
    var_mode = 1'b1; tick(4); vcnt = 0;
    fs = 1'b1; tick(4);
    send(1'b0, 8'hFF, 0, 8); tick(4);
    check("R4 mclk ignored", vcnt, 0);
    send(1'b1, 8'hC3, 0, 8); tick(4);
    fs = 1'b0; tick(4);
    check("R4 count", vcnt, 1); check("R4 word", vword, 8'hC3);
    vcnt = 0;
    fs = 1'b1; tick(4);
    send(1'b1, 8'h0F, 0, 5);
    fs = 1'b0; tick(6);
    send(1'b1, 8'hFF, 0, 3); tick(4);
    check("R5 dropped", vcnt, 0);
    check("R5 word kept", word, 8'hC3);
  endtask

  task automatic t_standby();
    var_mode = 1'b0; vcnt = 0;
    fs = 1'b1; tick(4); fs = 1'b0;
    tick(100);
    check("R7 not yet", standby, 0);
    tick(250);
    check("R7 standby", standby, 1);
    fixed_frame(8'h96);
    check("R8 cleared", standby, 0);
    check("R8 word", vword, 8'h96); check("R8 count", vcnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_fixed();
    t_fixed_dclk_ignored();
    t_restart();
    t_var();
    t_standby();
    finish_run();
  end
endmodule